// File: doc/BRIEF.md
# Programmable Interrupt Request Generator

This block collects a vector of event strobes into a sticky status register and turns those events into one interrupt request pin. Software reads the status to learn which events occurred and clears bits by writing ones to them. A separate enable register decides which status bits may drive the pin. Status bits record only that an event happened, not its order or its time. Any number of events may therefore collect into one request.

The pin has two modes. In level mode it stays active while any enabled status bit is set. In edge mode it emits pulses of a programmable width. A programmable hold-off separates pulses. After the hold-off a new pulse is issued only if an enabled status bit is still pending. A mode bit selects the active polarity of the pin. The register port is a plain single-cycle write strobe with a combinational read. The event vector and the pin are plain control signals, so there is no flow control to honour.

Register map (word address on `reg_addr`): 0 = status (write one to clear), 1 = enable, 2 = mode, 3 = edge count. In the mode register, bit 0 selects edge operation (1) or level operation (0). Bit 2 selects active-high (1) or active-low (0). All other mode bits read as zero. In the edge count register, bits 15:0 hold the pulse width in clock cycles and bits 31:24 hold the hold-off in units of 256 cycles. Bits 23:16 read as zero.

Top module: `irq_gen`

## Requirements
- R1: An asserted `evt_in` bit sets its status bit at the next clock edge, whether or not that bit is enabled. The status reads at address 0 on bits N_EVT-1:0.
- R2: Writing address 0 clears each status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R3: A status bit whose enable bit (address 1) is clear never makes the pin active.
- R4: In level mode the pin is active exactly while some status bit is set together with its enable bit. It turns inactive right after the clock edge that clears the last such bit.
- R5: Mode bit 2 chooses the active level: 1 means active-high and 0 means active-low. After reset the block is in level mode, active-low, with the pin high. The edge count then reads 0x00000021 and the status, enable and mode registers read 0.
- R6: In edge mode, a pending enabled status bit starts a pulse one clock after it is seen. The pulse lasts the programmed width in cycles, and a width of 0 gives 1 cycle.
- R7: Clearing the status during a pulse does not shorten it.
- R8: While the request stays pending, successive pulses are separated by exactly G*256+1 inactive cycles, where G is edge count bits 31:24.
- R9: If no enabled status bit is still pending when the hold-off ends, no further pulse is issued.
- R10: A mode write that changes bit 0 cancels any running pulse or hold-off, and the edge machine restarts idle.
- R11: The enable, mode and edge count registers read back what was written, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | N_EVT | Event strobes, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt request pin |

## Verification
Random sparse event vectors mixed with random write-one-to-clear masks are run in level mode under both polarities. These show whether status capture, clear precedence and enable gating track a bench model on every cycle. Directed single-event tests in edge mode measure pulse width and gap length with zero and non-zero hold-off. They separate a correct hold-off from a retrigger that ignores it, and a pulse held for its full width from one cut short by a status clear. A request withdrawn during the hold-off, and a mode toggle during a long pulse, show whether the edge machine stops where it must.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_MODE   = 2;
  localparam int ADDR_ECOUNT = 3;

  localparam int MODE_EDGE_BIT = 0;
  localparam int MODE_POL_BIT  = 2;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_PULSE = 2'd1,
    TMR_GAP   = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic             clr_we,
  input  logic [N_EVT-1:0] clr_mask,
  input  logic             en_we,
  input  logic [N_EVT-1:0] en_wdata,
  output logic [N_EVT-1:0] status,
  output logic [N_EVT-1:0] enable,
  output logic             pending
);
  logic [N_EVT-1:0] st_q, en_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= 1'b0;
      end else if (evt[i]) begin
        st_q[i] <= 1'b1;
      end else if (clr_we && clr_mask[i]) begin
        st_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_wdata;
    end
  end

  assign status  = st_q;
  assign enable  = en_q;
  assign pending = |(st_q & en_q);
endmodule

// File: rtl/irq_edge_timer.sv
module irq_edge_timer import irq_pkg::*; #(
  parameter int PW_W      = 16,
  parameter int GAP_W     = 8,
  parameter int GAP_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cancel,
  input  logic             pending,
  input  logic [PW_W-1:0]  width,
  input  logic [GAP_W-1:0] gap,
  output logic             active
);
  localparam int GAP_CW = GAP_W + GAP_SHIFT;
  localparam int TMR_W  = (PW_W > GAP_CW) ? PW_W : GAP_CW;

  tmr_state_e       state_q;
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] pw_load, gap_load;

  assign pw_load  = (width == '0) ? TMR_W'(1) : TMR_W'(width);
  assign gap_load = TMR_W'({gap, {GAP_SHIFT{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else if (cancel || !run) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        TMR_IDLE: begin
          if (pending) begin
            state_q <= TMR_PULSE;
            cnt_q   <= pw_load;
          end
        end
        TMR_PULSE: begin
          if (cnt_q <= TMR_W'(1)) begin
            if (gap == '0) begin
              state_q <= TMR_IDLE;
              cnt_q   <= '0;
            end else begin
              state_q <= TMR_GAP;
              cnt_q   <= gap_load;
            end
          end else begin
            cnt_q <= cnt_q - TMR_W'(1);
          end
        end
        TMR_GAP: begin
          if (cnt_q <= TMR_W'(1)) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - TMR_W'(1);
          end
        end
        default: begin
          state_q <= TMR_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign active = (state_q == TMR_PULSE);
endmodule

// File: rtl/irq_gen.sv
module irq_gen import irq_pkg::*; #(
  parameter int          N_EVT     = 8,
  parameter int          DW        = 32,
  parameter int          AW        = 2,
  parameter int          PW_W      = 16,
  parameter int          GAP_W     = 8,
  parameter int          GAP_SHIFT = 8,
  parameter logic [15:0] PW_RST    = 16'h0021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_o
);
  localparam int GAP_LSB = DW - GAP_W;

  logic             wr_st, wr_en, wr_mode, wr_cnt;
  logic [N_EVT-1:0] st_q, en_q;
  logic             pending;
  logic             edge_q, pol_q;
  logic [PW_W-1:0]  pw_q;
  logic [GAP_W-1:0] gap_q;
  logic             mode_flip;
  logic             t_act, act;

  assign wr_st   = reg_wr && (reg_addr == AW'(ADDR_STATUS));
  assign wr_en   = reg_wr && (reg_addr == AW'(ADDR_ENABLE));
  assign wr_mode = reg_wr && (reg_addr == AW'(ADDR_MODE));
  assign wr_cnt  = reg_wr && (reg_addr == AW'(ADDR_ECOUNT));

  irq_status_reg #(.N_EVT(N_EVT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_in),
    .clr_we   (wr_st),
    .clr_mask (reg_wdata[N_EVT-1:0]),
    .en_we    (wr_en),
    .en_wdata (reg_wdata[N_EVT-1:0]),
    .status   (st_q),
    .enable   (en_q),
    .pending  (pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      pol_q  <= 1'b0;
      pw_q   <= PW_W'(PW_RST);
      gap_q  <= '0;
    end else begin
      if (wr_mode) begin
        edge_q <= reg_wdata[MODE_EDGE_BIT];
        pol_q  <= reg_wdata[MODE_POL_BIT];
      end
      if (wr_cnt) begin
        pw_q  <= reg_wdata[PW_W-1:0];
        gap_q <= reg_wdata[DW-1:GAP_LSB];
      end
    end
  end

  assign mode_flip = wr_mode && (reg_wdata[MODE_EDGE_BIT] != edge_q);

  irq_edge_timer #(.PW_W(PW_W), .GAP_W(GAP_W), .GAP_SHIFT(GAP_SHIFT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (edge_q),
    .cancel  (mode_flip),
    .pending (pending),
    .width   (pw_q),
    .gap     (gap_q),
    .active  (t_act)
  );

  assign act   = edge_q ? t_act : pending;
  assign irq_o = pol_q ? act : ~act;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(ADDR_STATUS): reg_rdata[N_EVT-1:0] = st_q;
      AW'(ADDR_ENABLE): reg_rdata[N_EVT-1:0] = en_q;
      AW'(ADDR_MODE): begin
        reg_rdata[MODE_EDGE_BIT] = edge_q;
        reg_rdata[MODE_POL_BIT]  = pol_q;
      end
      default: begin
        reg_rdata[PW_W-1:0]      = pw_q;
        reg_rdata[DW-1:GAP_LSB]  = gap_q;
      end
    endcase
  end
endmodule

// File: rtl/irq_gen_chk.sv
module irq_gen_chk #(
  parameter int N_EVT = 8,
  parameter int PW_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_mode,
  input logic             cancel,
  input logic             pending,
  input logic             t_act,
  input logic             act,
  input logic             clr_we,
  input logic [N_EVT-1:0] clr_mask,
  input logic [N_EVT-1:0] evt,
  input logic [N_EVT-1:0] status,
  input logic [PW_W-1:0]  width
);
  logic [PW_W:0]   plen;
  logic [PW_W-1:0] wlat;
  logic            act_d, canc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen  <= '0;
      wlat  <= '0;
      act_d <= 1'b0;
      canc  <= 1'b0;
    end else begin
      act_d <= t_act;
      plen  <= t_act ? plen + 1'b1 : '0;
      if (!t_act) wlat <= width;
      canc  <= t_act ? (canc | cancel) : 1'b0;
    end
  end

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt))); // R1

  AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~status & ~($past(clr_mask) & {N_EVT{$past(clr_we)}})) == '0)); // R2

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && pending && !clr_we && !cancel) |=> (edge_mode || act)); // R4

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_d && !t_act && !canc) |-> (plen == ((wlat == '0) ? (PW_W+1)'(1) : (PW_W+1)'(wlat)))); // R7

  AST_MODE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !t_act); // R10
endmodule

bind irq_gen irq_gen_chk #(.N_EVT(N_EVT), .PW_W(PW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .edge_mode (edge_q),
  .cancel    (mode_flip),
  .pending   (pending),
  .t_act     (t_act),
  .act       (act),
  .clr_we    (wr_st),
  .clr_mask  (reg_wdata[N_EVT-1:0]),
  .evt       (evt_in),
  .status    (st_q),
  .width     (pw_q)
);

// File: tb/test_irq_gen.sv
`timescale 1ns/1ps
module test_irq_gen;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_in = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_gen i_irq_gen (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic fire(input logic [N-1:0] e);
    evt_in = e;
    tick();
    evt_in = '0;
  endtask

  function automatic logic pin(input logic pol, input logic a);
    return pol ? a : ~a;
  endfunction

  task automatic wait_act(output int waited);
    waited = 0;
    while (irq_o !== 1'b1 && waited < 2000) begin tick(); waited++; end
  endtask

  task automatic count_hi(output int n);
    n = 0;
    while (irq_o === 1'b1 && n < 70000) begin tick(); n++; end
  endtask

  task automatic count_lo(output int n);
    n = 0;
    while (irq_o === 1'b0 && n < 2000) begin tick(); n++; end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] st_m, en_m;
    logic pol_m;
    int w, hi, lo;
    void'($urandom(32'd4242));

    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R5 reset state
    chk("R5 reset pin", {31'd0, irq_o}, 32'd1);
    rd(0, d); chk("R5 reset status", d, 32'h0);
    rd(1, d); chk("R5 reset enable", d, 32'h0);
    rd(2, d); chk("R5 reset mode", d, 32'h0);
    rd(3, d); chk("R5 reset ecount", d, 32'h0000_0021);

    // R11 readback
    wr(1, 32'hFFFF_FFA5); rd(1, d); chk("R11 enable readback", d, 32'h0000_00A5);
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R11 mode readback", d, 32'h0000_0005);
    wr(3, 32'hFFFF_FFFF); rd(3, d); chk("R11 ecount readback", d, 32'hFF00_FFFF);
    wr(3, 32'h0000_0021);
    wr(2, 32'h0); wr(1, 32'h01); wr(0, 32'hFF);

    // R1 / R3 disabled event
    fire(8'h08);
    rd(0, d); chk("R1 status set", d, 32'h08);
    chk("R3 disabled no irq", {31'd0, irq_o}, 32'd1);
    // R2 write zero keeps, one clears, event wins
    wr(0, 32'h0); rd(0, d); chk("R2 zero keeps", d, 32'h08);
    wr(0, 32'h08); rd(0, d); chk("R2 one clears", d, 32'h0);
    evt_in = 8'h08; wr(0, 32'h08); evt_in = '0;
    rd(0, d); chk("R2 event beats clear", d, 32'h08);
    wr(0, 32'hFF);

    // R4 level, active low
    fire(8'h01);
    chk("R4 level active", {31'd0, irq_o}, 32'd0);
    tick(); tick();
    chk("R4 level held", {31'd0, irq_o}, 32'd0);
    wr(0, 32'h01);
    chk("R4 level released", {31'd0, irq_o}, 32'd1);

    // R5 polarity high
    wr(2, 32'h4);
    chk("R5 high idle", {31'd0, irq_o}, 32'd0);
    fire(8'h01);
    chk("R5 high active", {31'd0, irq_o}, 32'd1);
    wr(0, 32'hFF);

    // random level phase (R1 R2 R3 R4 R5)
    st_m = '0;
    for (int ph = 0; ph < 2; ph++) begin
      pol_m = ph[0];
      en_m  = N'($urandom);
      wr(2, {29'd0, pol_m, 2'b00});
      wr(1, {24'd0, en_m});
      for (int c = 0; c < 300; c++) begin
        logic [N-1:0] e, m;
        logic cw;
        e  = (($urandom % 4) == 0) ? N'($urandom) : '0;
        cw = (($urandom % 3) == 0);
        m  = N'($urandom);
        evt_in = e; reg_addr = 2'd0; reg_wr = cw; reg_wdata = {24'd0, m};
        tick();
        reg_wr = 1'b0; evt_in = '0;
        st_m = (st_m & ~(cw ? m : '0)) | e;
        rd(0, d); chk("R2 random status", d, {24'd0, st_m});
        chk("R4 random pin", {31'd0, irq_o}, {31'd0, pin(pol_m, |(st_m & en_m))});
      end
      wr(0, 32'hFF); st_m = '0;
    end

    // edge mode, active high, W=5 G=0
    wr(1, 32'h01); wr(0, 32'hFF);
    wr(3, 32'h0000_0005);
    wr(2, 32'h5);
    fire(8'h01);
    chk("R6 start delay", {31'd0, irq_o}, 32'd0);
    tick();
    chk("R6 started", {31'd0, irq_o}, 32'd1);
    count_hi(hi); chk("R6 width 5", hi, 5);
    count_lo(lo); chk("R8 gap zero", lo, 1);
    count_hi(hi); chk("R6 second width", hi, 5);

    // G=1 gap
    wr(3, 32'h0100_0005);
    wr(0, 32'hFF);
    repeat (600) tick();
    fire(8'h01);
    wait_act(w);
    count_hi(hi); chk("R6 width with gap", hi, 5);
    count_lo(lo); chk("R8 gap 257", lo, 257);

    // R9 withdraw during gap
    count_hi(hi);
    wr(0, 32'hFF);
    lo = 0;
    for (int c = 0; c < 600; c++) begin tick(); if (irq_o === 1'b1) lo++; end
    chk("R9 no pulse after withdraw", lo, 0);

    // R7 clear during pulse, W=12
    wr(3, 32'h0000_000C);
    fire(8'h01);
    wait_act(w);
    hi = 1;
    wr(0, 32'hFF);
    if (irq_o === 1'b1) hi++;
    count_hi(lo);
    hi = hi + (lo > 0 ? lo - 1 : 0);
    chk("R7 full width after clear", hi, 12);

    // R6 width zero gives one cycle
    wr(3, 32'h0);
    fire(8'h01);
    wait_act(w);
    wr(0, 32'hFF);
    chk("R6 zero width ended", {31'd0, irq_o}, 32'd0);
    repeat (5) tick();
    chk("R6 zero width no retrigger", {31'd0, irq_o}, 32'd0);

    // R10 mode toggle cancels pulse, W=200
    wr(3, 32'h0000_00C8);
    fire(8'h01);
    wait_act(w);
    wr(0, 32'hFF);
    chk("R10 pulse running", {31'd0, irq_o}, 32'd1);
    wr(2, 32'h4);
    wr(2, 32'h5);
    chk("R10 cancelled", {31'd0, irq_o}, 32'd0);
    repeat (10) tick();
    chk("R10 stays idle", {31'd0, irq_o}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule